// File: doc/BRIEF.md
# Dual-PLL Ping-Pong Hop Scheduler

This block decides, for every hop frame, which of two synthesizer tuners drives the datapath and which one is sent a retune command. A hop frame opens with a transition period and closes with a dwell period. The baseband marks both edges with single-cycle strobes. The block also samples the lock flags of the tuners when each dwell begins and keeps a record of any late lock.

It has two modes. In retune mode one tuner serves the transmit/receive pair. It is retuned at the start of each frame, so it has only the transition period to settle. In mux mode the two tuners swap roles every frame. While one tuner serves the current dwell, the other tunes to the following frequency. The idle tuner starts tuning at the start of this frame's transition and needs to lock only by the next frame's dwell, which gives it one dwell plus two transitions. The frequency word for a frame is captured on its frame strobe and handed to the tuner that is being commanded.

Top module: `pll_pingpong_sched`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `active_sel` is 0, `tune_req` is 2'b00 and `timing_viol` is 0.
- R2: In retune mode (`mux_mode`=0), the cycle after a `frame_start` strobe shows `tune_req` with only bit `active_sel` set, and `active_sel` does not change.
- R3: In mux mode, the first `frame_start` after reset, or after any frame taken in retune mode, sends the request to the tuner that is not active and leaves `active_sel` unchanged. After reset this means a request to PLL1 (`tune_req`=2'b10) while PLL0 stays active.
- R4: In mux mode, every later `frame_start` flips `active_sel` and sends the request to the tuner that was active until then.
- R5: `tune_word` takes the value of `next_freq` in the cycle after `frame_start` and holds it in every other cycle.
- R6: `active_sel` changes only in the cycle after a `frame_start` strobe, so it stays fixed through every dwell period.
- R7: A `dwell_start` strobe that arrives while `pll_lock[active_sel]` is 0 sets `timing_viol` on the next cycle. The lock flag of the idle tuner has no effect on the check.
- R8: Once set, `timing_viol` stays at 1 until reset.
- R9: `tune_req` has at most one bit set, and it is 2'b00 in every cycle that does not directly follow a `frame_start`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_start | input | 1 | Strobe marking the start of a frame's transition period |
| dwell_start | input | 1 | Strobe marking the start of a frame's dwell period |
| mux_mode | input | 1 | 1 = alternate both tuners, 0 = retune one tuner |
| next_freq | input | FREQ_W | Frequency word for the tuner commanded at this frame strobe |
| pll_lock | input | 2 | Lock flag of each tuner |
| tune_req | output | 2 | One-cycle tune command, one bit per tuner |
| tune_word | output | FREQ_W | Frequency word that goes with `tune_req` |
| active_sel | output | 1 | Index of the tuner that serves the datapath |
| timing_viol | output | 1 | Sticky flag: active tuner was not locked at dwell start |

## Verification
The bench builds the block with the default 24-bit frequency word. This is wide enough that distinct per-frame words show that the word is captured only on the frame strobe. A single vector walk alternates retune and mux frames, which covers priming after reset, toggling, re-priming after retune frames, and retuning while PLL1 is active. Directed cases drive the two lock flags on their own so that only the active tuner's flag can raise the violation, and they check that the flag stays set over later good dwells.

// File: rtl/pps_pkg.sv
// Package shared by the hop scheduler: tuner count and index helpers.
// Assumes exactly two tuners, which the ping-pong scheme needs.
package pps_pkg;
    localparam int NUM_PLL = 2;
    localparam int SEL_W   = $clog2(NUM_PLL);

    typedef logic [SEL_W-1:0]   pll_sel_t;
    typedef logic [NUM_PLL-1:0] pll_vec_t;

    // Index of the partner tuner in the pair
    function automatic pll_sel_t partner(input pll_sel_t s);
        return pll_sel_t'(NUM_PLL - 1) - s;
    endfunction
endpackage

// File: rtl/pps_role_ctrl.sv
// Role controller: picks the active tuner and the one to command on every
// frame strobe. Mux mode needs a priming frame before the first swap.
// Assumes frame_start is a single-cycle strobe.
module pps_role_ctrl
    import pps_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     frame_start,
    input  logic     mux_mode,
    output pll_sel_t active_sel,
    output pll_sel_t tune_sel,
    output logic     tune_fire
);
    logic primed;

    // Update roles on frame strobes only
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_sel <= '0;
            tune_sel   <= '0;
            tune_fire  <= 1'b0;
            primed     <= 1'b0;
        end else begin
            tune_fire <= frame_start;
            if (frame_start) begin
                if (!mux_mode) begin
                    tune_sel <= active_sel;
                    primed   <= 1'b0;
                end else if (primed) begin
                    tune_sel   <= active_sel;
                    active_sel <= partner(active_sel);
                end else begin
                    tune_sel <= partner(active_sel);
                    primed   <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/pps_word_reg.sv
// Frequency word holder: captures the next-frequency word on a frame strobe.
// Assumes the word is valid in the cycle the strobe is high.
module pps_word_reg #(
    parameter int FREQ_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [FREQ_W-1:0] din,
    output logic [FREQ_W-1:0] dout
);
    // Capture on load, hold otherwise
    always_ff @(posedge clk) begin
        if (!rst_n)    dout <= '0;
        else if (load) dout <= din;
    end
endmodule

// File: rtl/pps_lock_mon.sv
// Lock monitor: on each dwell strobe, checks the lock flag of the active
// tuner and keeps a sticky violation flag until reset.
// Assumes lock flags are synchronous to clk.
module pps_lock_mon
    import pps_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     dwell_start,
    input  pll_vec_t pll_lock,
    input  pll_sel_t active_sel,
    output logic     timing_viol
);
    // Set the flag on a late lock, never clear it except by reset
    always_ff @(posedge clk) begin
        if (!rst_n)
            timing_viol <= 1'b0;
        else if (dwell_start && !pll_lock[active_sel])
            timing_viol <= 1'b1;
    end
endmodule

// File: rtl/pll_pingpong_sched.sv
// Top of the two-tuner hop scheduler. Handles retune mode (one tuner) and
// mux mode (tuners alternate every frame), hands out one-cycle tune commands
// with the frequency word, and flags dwells whose tuner was not locked.
// Assumes frame_start and dwell_start are single-cycle strobes from baseband.
module pll_pingpong_sched
    import pps_pkg::*;
#(
    parameter int FREQ_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic              dwell_start,
    input  logic              mux_mode,
    input  logic [FREQ_W-1:0] next_freq,
    input  logic [1:0]        pll_lock,
    output logic [1:0]        tune_req,
    output logic [FREQ_W-1:0] tune_word,
    output logic              active_sel,
    output logic              timing_viol
);
    pll_sel_t act_q;
    pll_sel_t tsel_q;
    logic     fire_q;

    pps_role_ctrl u_role (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .mux_mode    (mux_mode),
        .active_sel  (act_q),
        .tune_sel    (tsel_q),
        .tune_fire   (fire_q)
    );

    pps_word_reg #(.FREQ_W(FREQ_W)) u_word (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (frame_start),
        .din   (next_freq),
        .dout  (tune_word)
    );

    pps_lock_mon u_lock (
        .clk         (clk),
        .rst_n       (rst_n),
        .dwell_start (dwell_start),
        .pll_lock    (pll_lock),
        .active_sel  (act_q),
        .timing_viol (timing_viol)
    );

    // Decode the per-tuner command lines
    for (genvar g = 0; g < NUM_PLL; g++) begin : g_req
        assign tune_req[g] = fire_q && (tsel_q == pll_sel_t'(g));
    end

    assign active_sel = act_q;
endmodule

// File: rtl/pll_pingpong_sched_chk.sv
// Checker bound to the scheduler top; watches port behaviour over time.
module pll_pingpong_sched_chk #(
    parameter int FREQ_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              frame_start,
    input logic              dwell_start,
    input logic              mux_mode,
    input logic [FREQ_W-1:0] next_freq,
    input logic [1:0]        pll_lock,
    input logic [1:0]        tune_req,
    input logic [FREQ_W-1:0] tune_word,
    input logic              active_sel,
    input logic              timing_viol
);
    // R9
    req_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tune_req));
    // R9
    req_only_after_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tune_req != 2'b00) |-> $past(frame_start));
    // R6
    active_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(active_sel) |-> $past(frame_start));
    // R2
    retune_keeps_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && !mux_mode) |=> $stable(active_sel));
    // R5
    word_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (tune_word == $past(next_freq)));
    // R7
    late_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dwell_start && !pll_lock[active_sel]) |=> timing_viol);
    // R8
    viol_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        timing_viol |=> timing_viol);
endmodule

bind pll_pingpong_sched pll_pingpong_sched_chk #(.FREQ_W(FREQ_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .dwell_start (dwell_start),
    .mux_mode    (mux_mode),
    .next_freq   (next_freq),
    .pll_lock    (pll_lock),
    .tune_req    (tune_req),
    .tune_word   (tune_word),
    .active_sel  (active_sel),
    .timing_viol (timing_viol)
);

// File: tb/pll_pingpong_sched_tb_top.sv
module pll_pingpong_sched_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int FREQ_W     = 24;
    localparam int NVEC       = 8;

    // Vector: {mux_mode, expected tune_req, expected active_sel}
    typedef struct packed {
        logic       mux;
        logic [1:0] req;
        logic       act;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{1'b1, 2'b10, 1'b0},   // R3 priming after reset
        '{1'b1, 2'b01, 1'b1},   // R4 swap
        '{1'b1, 2'b10, 1'b0},   // R4 swap back
        '{1'b0, 2'b01, 1'b0},   // R2 retune PLL0
        '{1'b0, 2'b01, 1'b0},   // R2 again
        '{1'b1, 2'b10, 1'b0},   // R3 re-prime after retune
        '{1'b1, 2'b01, 1'b1},   // R4 swap
        '{1'b0, 2'b10, 1'b1}    // R2 retune while PLL1 active
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              frame_start = 1'b0;
    logic              dwell_start = 1'b0;
    logic              mux_mode = 1'b0;
    logic [FREQ_W-1:0] next_freq = '0;
    logic [1:0]        pll_lock = 2'b11;
    logic [1:0]        tune_req;
    logic [FREQ_W-1:0] tune_word;
    logic              active_sel;
    logic              timing_viol;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pll_pingpong_sched #(.FREQ_W(FREQ_W)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .dwell_start (dwell_start),
        .mux_mode    (mux_mode),
        .next_freq   (next_freq),
        .pll_lock    (pll_lock),
        .tune_req    (tune_req),
        .tune_word   (tune_word),
        .active_sel  (active_sel),
        .timing_viol (timing_viol)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        frame_start = 1'b0;
        dwell_start = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Pulse frame_start for one cycle; outputs sampled at the next negedge
    task automatic frame(input logic mux, input logic [FREQ_W-1:0] f);
        mux_mode    = mux;
        next_freq   = f;
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
    endtask

    task automatic dwell(input logic [1:0] lk);
        pll_lock    = lk;
        dwell_start = 1'b1;
        @(negedge clk);
        dwell_start = 1'b0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        // R1 state held in reset and on the first cycle after
        @(negedge clk);
        check(active_sel == 1'b0 && tune_req == 2'b00 && timing_viol == 1'b0,
              "R1 in reset", {active_sel, tune_req, timing_viol}, 0);
        do_reset();
        check(active_sel == 1'b0 && tune_req == 2'b00 && timing_viol == 1'b0,
              "R1 after reset", {active_sel, tune_req, timing_viol}, 0);

        // Vector walk: R2 R3 R4 R5
        for (int i = 0; i < NVEC; i++) begin
            frame(VECS[i].mux, FREQ_W'(24'h100000 + i * 24'h0123));
            check(tune_req == VECS[i].req, "R2/R3/R4 tune_req", tune_req, VECS[i].req);
            check(active_sel == VECS[i].act, "R2/R3/R4 active_sel", active_sel, VECS[i].act);
            check(tune_word == FREQ_W'(24'h100000 + i * 24'h0123), "R5 word",
                  tune_word, 24'h100000 + i * 24'h0123);
            // Idle cycles between frames: R9 no request, R5 hold, R6 no change
            mux_mode  = ~mux_mode;
            next_freq = 24'hABCDEF;
            repeat (2) @(negedge clk);
            check(tune_req == 2'b00, "R9 idle", tune_req, 0);
            check(tune_word == FREQ_W'(24'h100000 + i * 24'h0123), "R5 hold",
                  tune_word, 24'h100000 + i * 24'h0123);
            check(active_sel == VECS[i].act, "R6 hold", active_sel, VECS[i].act);
        end
        check(timing_viol == 1'b0, "R7 no dwell no flag", timing_viol, 0);

        // R7: idle tuner unlocked does not matter (active PLL0 locked)
        do_reset();
        frame(1'b1, 24'h000111);          // prime: PLL1 tuning, PLL0 active
        dwell(2'b01);
        @(negedge clk);
        check(timing_viol == 1'b0, "R7 idle lock ignored", timing_viol, 0);

        // R7: active PLL0 unlocked at dwell start
        dwell(2'b10);
        check(timing_viol == 1'b1, "R7 late lock PLL0", timing_viol, 1);

        // R8: flag stays over later good frames and dwells
        frame(1'b1, 24'h000222);
        dwell(2'b11);
        repeat (3) @(negedge clk);
        check(timing_viol == 1'b1, "R8 sticky", timing_viol, 1);

        // R7: with PLL1 active, only PLL1's flag counts
        do_reset();
        check(timing_viol == 1'b0, "R1 flag cleared by reset", timing_viol, 0);
        frame(1'b1, 24'h000333);
        frame(1'b1, 24'h000444);
        check(active_sel == 1'b1, "R4 PLL1 active", active_sel, 1);
        dwell(2'b10);
        check(timing_viol == 1'b0, "R7 PLL1 locked", timing_viol, 0);
        dwell(2'b01);
        check(timing_viol == 1'b1, "R7 late lock PLL1", timing_viol, 1);

        // R9: single-cycle request pulse
        do_reset();
        frame(1'b0, 24'h000555);
        check(tune_req == 2'b01, "R2 request", tune_req, 1);
        @(negedge clk);
        check(tune_req == 2'b00, "R9 pulse width", tune_req, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule